// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Address Front End

This block is the receive side of a two-wire (I2C) slave for a serial EEPROM. It samples the clock and data lines in the system clock domain and detects start and stop conditions. It shifts in the slave address byte and checks that byte against a fixed device-type code and two board-level select pins. When both match, it acknowledges and then collects a two-byte word address.

From the word address it derives a 15-bit location and splits that location into a page number and a byte offset within the page. It also produces a flag that steers the access to either the storage array or a control register. A storage back end receives these fields together with a single-cycle valid strobe and a read/write indication. The block only pulls the data line low, and does so only while acknowledging. On a mismatch it falls silent until the next start condition.

Top module: `eep_i2c_front`

## Requirements
- R1: The slave address byte is accepted only when its bits 7..4 equal binary 1010; any other value gives no acknowledge and no strobe.
- R2: Bits 3 and 2 of the slave address byte must equal sel_i[1] and sel_i[0] respectively; otherwise there is no acknowledge and no strobe.
- R3: Bit 0 of an accepted slave address byte sets rd_o (1 = read, 0 = write). A read is acknowledged, takes no word address and produces no strobe.
- R4: After a rejected slave address byte, the block ignores the bus until the next start condition. Later bytes get no acknowledge, even ones that would match.
- R5: An acknowledge asserts sda_oe_o (which pulls the data line low) from the clock fall after the eighth bit until the ninth clock falls. sda_oe_o is low while data bits are clocked in.
- R6: After an accepted write address byte, the block takes two word-address bytes, the high byte first and then the low byte, and acknowledges each of them.
- R7: addr_o is {high[6:0], low[7:0]}. page_o is addr_o[14:6] and offset_o is addr_o[5:0].
- R8: ctrl_sel_o equals bit 7 of the high word-address byte (0 = array, 1 = control register).
- R9: addr_valid_o pulses for exactly one clock after the ninth clock of the low address byte. addr_o, page_o, offset_o and ctrl_sel_o change only with that pulse.
- R10: A start condition (data falls while the clock is high) restarts address reception at any point. A stop condition (data rises while the clock is high) returns the block to standby.
- R11: During reset sda_oe_o, addr_valid_o and rd_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sel_i | input | 2 | Device select pins compared with address bits 3..2 |
| sda_oe_o | output | 1 | Pull data line low when 1 (open-drain enable) |
| rd_o | output | 1 | Operation of the last accepted address byte, 1 = read |
| ctrl_sel_o | output | 1 | 1 = control register access, 0 = array access |
| addr_o | output | 15 | Decoded word address |
| page_o | output | 9 | Page number, addr_o[14:6] |
| offset_o | output | 6 | Byte within page, addr_o[5:0] |
| addr_valid_o | output | 1 | One-cycle strobe: address fields are new |

## Verification
A wrong bit count or state shows up as an acknowledge on the wrong clock, or as a missing acknowledge, on the very next byte. It can also produce a strobe that is missing or comes too early. All of these appear on sda_oe_o or addr_valid_o within one byte time. A wrong slice of the address bytes shows up as a wrong addr_o, page_o, offset_o or ctrl_sel_o at the strobe. A standby state that leaks is caught by sending a matching byte without a start condition and checking that no acknowledge follows. Restart and stop handling are checked by breaking off an address sequence part way through and checking that only the completed sequence produces a strobe.

// File: rtl/eep_i2c_pkg.sv
package eep_i2c_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_HOLD
  } fe_state_e;
endpackage

// File: rtl/eep_i2c_sync.sv
module eep_i2c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // bus idles high, so reset to 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign sync_o[g] = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/eep_i2c_byte_rx.sv
module eep_i2c_byte_rx #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_i,
  output logic [BITS-1:0] data_o,
  output logic            byte_done_o,
  output logic            ack_end_o
);
  localparam int unsigned CNT_W = $clog2(BITS + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;

  // cnt counts rising edges; the fall after a start sees cnt==0 and is ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i || !en_i) begin
      cnt_q <= '0;
    end else begin
      if (scl_rise_i) begin
        if (cnt_q < LAST_BIT) sh_q <= {sh_q[BITS-2:0], sda_i};
        if (cnt_q <= LAST_BIT) cnt_q <= cnt_q + 1'b1;
      end else if (scl_fall_i && cnt_q == ACK_BIT) begin
        cnt_q <= '0;
      end
    end
  end

  assign data_o      = sh_q;
  assign byte_done_o = en_i & ~clr_i & scl_fall_i & (cnt_q == LAST_BIT);
  assign ack_end_o   = en_i & ~clr_i & scl_fall_i & (cnt_q == ACK_BIT);

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACK_BIT);
  a_r5_done_before_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !ack_end_o);
endmodule

// File: rtl/eep_addr_split.sv
module eep_addr_split #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned OFS_W  = 6
) (
  input  logic [7:0]              hi_i,
  input  logic [7:0]              lo_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic                    ctrl_o,
  output logic [ADDR_W-OFS_W-1:0] page_o,
  output logic [OFS_W-1:0]        offset_o
);
  localparam int unsigned HI_BITS = ADDR_W - 8;

  assign addr_o   = {hi_i[HI_BITS-1:0], lo_i};
  assign ctrl_o   = hi_i[7];
  assign page_o   = addr_o[ADDR_W-1:OFS_W];
  assign offset_o = addr_o[OFS_W-1:0];
endmodule

// File: rtl/eep_i2c_front.sv
module eep_i2c_front
  import eep_i2c_pkg::*;
#(
  parameter logic [3:0]  DEV_TYPE = 4'b1010,
  parameter int unsigned SYNC_STG = 2,
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned OFS_W    = 6,
  localparam int unsigned PAGE_W  = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        sel_i,
  output logic              sda_oe_o,
  output logic              rd_o,
  output logic              ctrl_sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic              addr_valid_o
);
  logic [1:0] line_s, line_rise, line_fall;
  logic       scl_s, scl_rise, scl_fall, sda_s;
  logic       start_evt, stop_evt;

  eep_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sda_i, scl_i}),
    .sync_o (line_s),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  assign scl_s     = line_s[0];
  assign scl_rise  = line_rise[0];
  assign scl_fall  = line_fall[0];
  assign sda_s     = line_s[1];
  assign start_evt = line_fall[1] & scl_s;
  assign stop_evt  = line_rise[1] & scl_s;

  fe_state_e          state_q;
  logic               rx_en;
  logic [BYTE_W-1:0]  rx_data;
  logic               byte_done, ack_end;
  logic               ack_q, rd_q, valid_q;
  logic [7:0]         hi_stg_q, lo_stg_q, hi_q, lo_q;
  logic               dev_match;

  assign rx_en = (state_q == ST_DEV) || (state_q == ST_AHI) || (state_q == ST_ALO);

  eep_i2c_byte_rx #(.BITS(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en),
    .clr_i      (start_evt | stop_evt),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .data_o     (rx_data),
    .byte_done_o(byte_done),
    .ack_end_o  (ack_end)
  );

  assign dev_match = (rx_data[7:4] == DEV_TYPE) && (rx_data[3:2] == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      valid_q  <= 1'b0;
      hi_stg_q <= '0;
      lo_stg_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_evt) begin
        state_q <= ST_DEV;
        ack_q   <= 1'b0;
      end else if (stop_evt) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
      end else if (byte_done) begin
        unique case (state_q)
          ST_DEV: begin
            if (dev_match) begin
              ack_q <= 1'b1;
              rd_q  <= rx_data[0];
            end else begin
              state_q <= ST_IDLE;  // standby, wait for next start
            end
          end
          ST_AHI: begin
            ack_q    <= 1'b1;
            hi_stg_q <= rx_data;
          end
          ST_ALO: begin
            ack_q    <= 1'b1;
            lo_stg_q <= rx_data;
          end
          default: ;
        endcase
      end else if (ack_end) begin
        ack_q <= 1'b0;
        unique case (state_q)
          ST_DEV: state_q <= rd_q ? ST_HOLD : ST_AHI;
          ST_AHI: state_q <= ST_ALO;
          ST_ALO: begin
            state_q <= ST_HOLD;
            hi_q    <= hi_stg_q;
            lo_q    <= lo_stg_q;
            valid_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  eep_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_split (
    .hi_i    (hi_q),
    .lo_i    (lo_q),
    .addr_o  (addr_o),
    .ctrl_o  (ctrl_sel_o),
    .page_o  (page_o),
    .offset_o(offset_o)
  );

  assign sda_oe_o     = ack_q;
  assign rd_o         = rd_q;
  assign addr_valid_o = valid_q;

  a_r4_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);
  a_r5_ack_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);
  a_r9_valid_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> $past(sda_oe_o));
  a_r9_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_o |-> $stable(addr_o));
  a_r10_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (state_q == ST_DEV) && !sda_oe_o);
  a_r10_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> (state_q == ST_IDLE));
endmodule

// File: tb/eep_i2c_front_bench.sv
module eep_i2c_front_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 10;

  // {sel[1:0], slave byte, high addr byte, low addr byte}
  localparam logic [25:0] VEC [NVEC] = '{
    {2'b00, 8'hA0, 8'h00, 8'h00},
    {2'b01, 8'hA4, 8'h7F, 8'hFF},
    {2'b10, 8'hA8, 8'h81, 8'h40},
    {2'b11, 8'hAC, 8'h2A, 8'hC5},
    {2'b00, 8'hA1, 8'h00, 8'h00},
    {2'b01, 8'hA0, 8'h12, 8'h34},
    {2'b00, 8'hB0, 8'h55, 8'h66},
    {2'b10, 8'h28, 8'h01, 8'h02},
    {2'b11, 8'hAE, 8'hFF, 8'h3F},
    {2'b10, 8'hA9, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_drv = 1'b1;
  logic [1:0]  sel = 2'b00;
  logic        sda_oe, rd, ctrl_sel, addr_valid;
  logic [14:0] addr;
  logic [8:0]  page;
  logic [5:0]  offset;
  wire         sda_line = sda_drv & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  logic        leak = 1'b0;
  logic        done = 1'b0;
  logic [14:0] cap_addr = '0;
  logic [8:0]  cap_page = '0;
  logic [5:0]  cap_ofs = '0;
  logic        cap_ctrl = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eep_i2c_front u_eep_i2c_front (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sel_i       (sel),
    .sda_oe_o    (sda_oe),
    .rd_o        (rd),
    .ctrl_sel_o  (ctrl_sel),
    .addr_o      (addr),
    .page_o      (page),
    .offset_o    (offset),
    .addr_valid_o(addr_valid)
  );

  always @(negedge clk) begin
    if (addr_valid) begin
      strobes++;
      cap_addr = addr;
      cap_page = page;
      cap_ofs  = offset;
      cap_ctrl = ctrl_sel;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wclk(5);
    scl = 1'b1;     wclk(5);
    sda_drv = 1'b0; wclk(5);
    scl = 1'b0;     wclk(5);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wclk(5);
    scl = 1'b1;     wclk(5);
    sda_drv = 1'b1; wclk(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wclk(5);
      scl = 1'b1;     wclk(4);
      if (sda_oe) leak = 1'b1;
      wclk(4);
      scl = 1'b0;     wclk(1);
    end
    sda_drv = 1'b1; wclk(5);
    scl = 1'b1;     wclk(4);
    acked = sda_oe;
    wclk(4);
    scl = 1'b0;     wclk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    int   s0;
    logic [14:0] held;

    wclk(3);
    // R11: reset state
    chk(sda_oe == 1'b0, "R11 sda_oe in reset", int'(sda_oe), 0);
    chk(addr_valid == 1'b0, "R11 valid in reset", int'(addr_valid), 0);
    chk(rd == 1'b0, "R11 rd in reset", int'(rd), 0);
    rst_n = 1'b1;
    wclk(5);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  vs;
      logic [7:0]  sb, hb, lb;
      logic        match, is_rd;
      logic [14:0] exp_addr;
      {vs, sb, hb, lb} = VEC[v];
      sel = vs;
      match = (sb[7:4] == 4'b1010) && (sb[3:2] == vs);
      is_rd = sb[0];
      exp_addr = {hb[6:0], lb};
      s0 = strobes;
      leak = 1'b0;
      bus_start();
      send_byte(sb, ack);
      chk(ack == match, "R1 R2 slave address acknowledge", int'(ack), int'(match));
      if (match && is_rd) begin
        chk(rd == 1'b1, "R3 read indication", int'(rd), 1);
        send_byte(8'h00, ack);
        chk(ack == 1'b0, "R3 no word address after read", int'(ack), 0);
      end else if (match) begin
        chk(rd == 1'b0, "R3 write indication", int'(rd), 0);
        send_byte(hb, ack);
        chk(ack == 1'b1, "R6 high byte acknowledge", int'(ack), 1);
        chk(strobes == s0, "R9 no strobe before low byte", strobes - s0, 0);
        send_byte(lb, ack);
        chk(ack == 1'b1, "R6 low byte acknowledge", int'(ack), 1);
        chk(strobes == s0 + 1, "R9 single strobe", strobes - s0, 1);
        chk(cap_addr == exp_addr, "R7 address", int'(cap_addr), int'(exp_addr));
        chk(cap_page == exp_addr[14:6], "R7 page", int'(cap_page), int'(exp_addr[14:6]));
        chk(cap_ofs == lb[5:0], "R7 offset", int'(cap_ofs), int'(lb[5:0]));
        chk(cap_ctrl == hb[7], "R8 array/control select", int'(cap_ctrl), int'(hb[7]));
      end else begin
        send_byte(hb, ack);
        chk(ack == 1'b0, "R4 no acknowledge after mismatch", int'(ack), 0);
      end
      chk(strobes == s0 + ((match && !is_rd) ? 1 : 0), "R1 R2 R3 strobe count",
          strobes - s0, (match && !is_rd) ? 1 : 0);
      chk(leak == 1'b0, "R5 released during data bits", int'(leak), 0);
      bus_stop();
      wclk(5);
    end

    // R4: rejected then a matching byte without start
    sel = 2'b00;
    s0 = strobes;
    bus_start();
    send_byte(8'hA6, ack);
    chk(ack == 1'b0, "R2 select mismatch", int'(ack), 0);
    send_byte(8'hA0, ack);
    chk(ack == 1'b0, "R4 standby ignores matching byte", int'(ack), 0);
    chk(strobes == s0, "R4 no strobe in standby", strobes - s0, 0);
    bus_stop();
    wclk(5);

    // R10: repeated start mid address restarts reception
    s0 = strobes;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h55, ack);
    chk(ack == 1'b1, "R6 high byte before restart", int'(ack), 1);
    bus_start();
    send_byte(8'hA0, ack);
    chk(ack == 1'b1, "R10 address byte after restart", int'(ack), 1);
    send_byte(8'h01, ack);
    send_byte(8'h02, ack);
    chk(strobes == s0 + 1, "R10 one strobe after restart", strobes - s0, 1);
    chk(cap_addr == 15'h0102, "R10 restart address", int'(cap_addr), 'h0102);
    bus_stop();
    wclk(5);

    // R9: fields held after strobe
    held = addr;
    wclk(50);
    chk(addr == held, "R9 address held", int'(addr), int'(held));
    chk(addr_valid == 1'b0, "R9 strobe idle", int'(addr_valid), 0);

    // R10: stop mid address returns to standby
    s0 = strobes;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h11, ack);
    bus_stop();
    sda_drv = 1'b1; scl = 1'b0; wclk(5);
    send_byte(8'h22, ack);
    chk(ack == 1'b0, "R10 stop returns to standby", int'(ack), 0);
    chk(strobes == s0, "R10 no strobe after stop", strobes - s0, 0);
    chk(addr == held, "R10 address unchanged", int'(addr), int'(held));
    bus_stop();
    wclk(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule